// File: doc/BRIEF.md
# Reservation Station Bank with Tag Wakeup

This block holds a small pool of pending floating-point operations between an in-order issue stage and one shared functional unit. Every source operand arrives either as a value or as the tag of the station that will produce it. The block watches a result broadcast bus made of a valid, a tag and a value. When a broadcast tag matches a waiting operand, the block latches the value and the operand becomes ready. An operation whose operands are all present can leave before older operations that are still waiting, so work runs out of program order.

Each cycle, one ready entry is offered to the functional unit through a valid/ready handshake. By default the oldest ready entry is offered. A parameter can select a fixed lowest-index policy instead. A dispatched entry stays occupied until the unit broadcasts the result with that entry's tag, and then the entry is released. The issue side stalls when no entry is free. A broadcast that arrives in the same cycle as an issue depending on it is forwarded into the new entry, so the wakeup is not lost.

Top module: `rs_bank`

## Requirements
- R1: After reset every entry is free: `iss_ready` is 1, `fu_valid` is 0, and `iss_tag` equals the tag of entry 0 (1 with default parameters).
- R2: `iss_ready` is low exactly when every entry is occupied. While it is low, asserting `iss_valid` changes no entry and nothing new is offered at the dispatch port.
- R3: Entry i owns the fixed tag TAG_BASE+i (1 to 4 by default). Tag 0 is reserved and means "value present". `iss_tag` shows the tag of the lowest-index free entry, and an accepted operation is written into that entry.
- R4: A source tag of 0 makes the block take the supplied value as the operand. An operation issued with both tags 0 is offered to the unit in the next cycle, carrying those values.
- R5: When `bc_valid` is high and `bc_tag` equals a nonzero waiting source tag of an occupied entry, `bc_val` is captured and that source becomes ready from the next cycle.
- R6: When an accepted issue names a source tag equal to the `bc_tag` of a broadcast in the same cycle, the new entry stores `bc_val` and treats that source as ready.
- R7: `fu_valid` is high exactly when some occupied, not yet dispatched entry has both sources ready. Once an entry is eligible, it stays offered until a cycle with `fu_ready` high takes it.
- R8: When several entries are eligible, the one issued earliest is offered, whatever its index.
- R9: An entry is dispatched at most once. It stays occupied until a broadcast carries its own tag, and it is free in the cycle after that broadcast.
- R10: The dispatch port carries the chosen entry's opcode, both operand values, the immediate, and its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A free entry exists |
| iss_tag | output | TAG_W | Tag the next accepted operation receives |
| iss_op | input | OP_W | Opcode of the issued operation |
| iss_src1_tag | input | TAG_W | Producer tag of source 1, 0 when the value is given |
| iss_src1_val | input | VAL_W | Value of source 1 |
| iss_src2_tag | input | TAG_W | Producer tag of source 2, 0 when the value is given |
| iss_src2_val | input | VAL_W | Value of source 2 |
| iss_imm | input | IMM_W | Immediate or address field |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | VAL_W | Broadcast result value |
| fu_valid | output | 1 | An eligible operation is offered |
| fu_ready | input | 1 | Functional unit accepts the offer |
| fu_op | output | OP_W | Offered opcode |
| fu_val1 | output | VAL_W | Offered operand 1 |
| fu_val2 | output | VAL_W | Offered operand 2 |
| fu_imm | output | IMM_W | Offered immediate |
| fu_tag | output | TAG_W | Tag the unit must return with the result |

## Verification
`iss_ready`, `iss_tag` and the whole dispatch port are decoded from registered state alone. After a rising edge, they reflect the issue, wakeup, dispatch and release of that edge, so an issued ready operation, a woken operand and a released entry each appear one cycle after their stimulus. The bench drives inputs at the falling edge and keeps a reference model of the entries, which it updates at each rising edge from the driven inputs. It compares all outputs against that model one time unit after the next falling edge. The directed checks read the ports at that same sampling point, with idle inputs, so the model and the design never disagree about which edge has occurred.

// File: rtl/rs_pkg.sv
package rs_pkg;
   // selection policy among eligible entries
   typedef enum logic [0:0] {
      PICK_OLDEST = 1'b0,
      PICK_LOWEST = 1'b1
   } pick_policy_e;
endpackage

// File: rtl/rs_entry.sv
// One station: operand capture, forwarding at issue, dispatch and release.
module rs_entry #(
   parameter int TAG_W   = 3,
   parameter int VAL_W   = 32,
   parameter int OP_W    = 4,
   parameter int IMM_W   = 8,
   parameter int ENT_TAG = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc,
   input  logic [OP_W-1:0]  in_op,
   input  logic [TAG_W-1:0] in_t1,
   input  logic [VAL_W-1:0] in_v1,
   input  logic [TAG_W-1:0] in_t2,
   input  logic [VAL_W-1:0] in_v2,
   input  logic [IMM_W-1:0] in_imm,
   input  logic             bc_valid,
   input  logic [TAG_W-1:0] bc_tag,
   input  logic [VAL_W-1:0] bc_val,
   input  logic             disp,
   output logic             busy_o,
   output logic             ready_o,
   output logic [OP_W-1:0]  op_o,
   output logic [VAL_W-1:0] v1_o,
   output logic [VAL_W-1:0] v2_o,
   output logic [IMM_W-1:0] imm_o
);
   localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(ENT_TAG);

   logic             busy_q, sent_q;
   logic [TAG_W-1:0] t1_q, t2_q;
   logic [VAL_W-1:0] v1_q, v2_q;
   logic [OP_W-1:0]  op_q;
   logic [IMM_W-1:0] imm_q;

   logic fwd1, fwd2, hit1, hit2, own_done;

   // R6: same-cycle broadcast forwarded into a fresh entry
   assign fwd1 = bc_valid && (in_t1 != '0) && (in_t1 == bc_tag);
   assign fwd2 = bc_valid && (in_t2 != '0) && (in_t2 == bc_tag);
   // R5: wakeup of a waiting source
   assign hit1 = bc_valid && (t1_q != '0) && (t1_q == bc_tag);
   assign hit2 = bc_valid && (t2_q != '0) && (t2_q == bc_tag);
   // R9: own result seen on the bus
   assign own_done = sent_q && bc_valid && (bc_tag == MY_TAG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sent_q <= 1'b0;
         t1_q   <= '0;
         t2_q   <= '0;
         v1_q   <= '0;
         v2_q   <= '0;
         op_q   <= '0;
         imm_q  <= '0;
      end else if (alloc) begin
         busy_q <= 1'b1;
         sent_q <= 1'b0;
         op_q   <= in_op;
         imm_q  <= in_imm;
         t1_q   <= fwd1 ? '0 : in_t1;
         v1_q   <= fwd1 ? bc_val : in_v1;
         t2_q   <= fwd2 ? '0 : in_t2;
         v2_q   <= fwd2 ? bc_val : in_v2;
      end else if (busy_q) begin
         if (hit1) begin
            t1_q <= '0;
            v1_q <= bc_val;
         end
         if (hit2) begin
            t2_q <= '0;
            v2_q <= bc_val;
         end
         if (disp) begin
            sent_q <= 1'b1;
         end
         if (own_done) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
         end
      end
   end

   assign busy_o  = busy_q;
   assign ready_o = busy_q && !sent_q && (t1_q == '0) && (t2_q == '0);
   assign op_o    = op_q;
   assign v1_o    = v1_q;
   assign v2_o    = v2_q;
   assign imm_o   = imm_q;
endmodule

// File: rtl/rs_free_pick.sv
// Lowest-index free entry finder.
module rs_free_pick #(
   parameter int N = 4,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     busy,
   output logic             any_free,
   output logic [N-1:0]     free_oh,
   output logic [IDX_W-1:0] free_idx
);
   always_comb begin
      any_free = 1'b0;
      free_oh  = '0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            any_free   = 1'b1;
            free_oh    = '0;
            free_oh[i] = 1'b1;
            free_idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/rs_age_pick.sv
// Selects one eligible entry: oldest by issue order, or lowest index.
module rs_age_pick #(
   parameter int N = 4,
   parameter rs_pkg::pick_policy_e POLICY = rs_pkg::PICK_OLDEST,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     alloc,
   input  logic [N-1:0]     ready,
   output logic [N-1:0]     grant,
   output logic             any_ready,
   output logic [IDX_W-1:0] grant_idx
);
   generate
      if (POLICY == rs_pkg::PICK_OLDEST) begin : g_age
         // older_q[j][i] set: entry j was issued before entry i
         logic [N-1:0] older_q [N];
         logic [N-1:0] blocked;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < N; i++) older_q[i] <= '0;
            end else begin
               for (int i = 0; i < N; i++) begin
                  for (int j = 0; j < N; j++) begin
                     if (alloc[j]) older_q[i][j] <= (i != j);
                     else if (alloc[i]) older_q[i][j] <= 1'b0;
                  end
               end
            end
         end

         always_comb begin
            for (int i = 0; i < N; i++) begin
               blocked[i] = 1'b0;
               for (int j = 0; j < N; j++) begin
                  if (ready[j] && older_q[j][i]) blocked[i] = 1'b1;
               end
               grant[i] = ready[i] && !blocked[i];
            end
         end
      end else begin : g_fixed
         logic unused_fixed;
         assign unused_fixed = ^{clk, rst_n, alloc};

         always_comb begin
            grant = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (ready[i]) begin
                  grant    = '0;
                  grant[i] = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) grant_idx = IDX_W'(i);
      end
   end

   assign any_ready = |ready;
endmodule

// File: rtl/rs_bank.sv
// Reservation station bank: issue, tag wakeup, selection, dispatch, release.
module rs_bank #(
   parameter int NUM_ENT  = 4,
   parameter int TAG_W    = 3,
   parameter int VAL_W    = 32,
   parameter int OP_W     = 4,
   parameter int IMM_W    = 8,
   parameter int TAG_BASE = 1,
   parameter rs_pkg::pick_policy_e PICK = rs_pkg::PICK_OLDEST
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iss_valid,
   output logic             iss_ready,
   output logic [TAG_W-1:0] iss_tag,
   input  logic [OP_W-1:0]  iss_op,
   input  logic [TAG_W-1:0] iss_src1_tag,
   input  logic [VAL_W-1:0] iss_src1_val,
   input  logic [TAG_W-1:0] iss_src2_tag,
   input  logic [VAL_W-1:0] iss_src2_val,
   input  logic [IMM_W-1:0] iss_imm,
   input  logic             bc_valid,
   input  logic [TAG_W-1:0] bc_tag,
   input  logic [VAL_W-1:0] bc_val,
   output logic             fu_valid,
   input  logic             fu_ready,
   output logic [OP_W-1:0]  fu_op,
   output logic [VAL_W-1:0] fu_val1,
   output logic [VAL_W-1:0] fu_val2,
   output logic [IMM_W-1:0] fu_imm,
   output logic [TAG_W-1:0] fu_tag
);
   localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

   // elaboration-time parameter checks
   generate
      if (NUM_ENT < 2) begin : g_bad_depth
         $error("rs_bank: NUM_ENT must be at least 2");
      end
      if (TAG_BASE < 1) begin : g_bad_base
         $error("rs_bank: TAG_BASE must be nonzero, tag 0 means ready");
      end
      if (TAG_BASE + NUM_ENT > (1 << TAG_W)) begin : g_bad_tagw
         $error("rs_bank: TAG_W too narrow for the entry tags");
      end
      if (VAL_W < 1 || OP_W < 1 || IMM_W < 1) begin : g_bad_width
         $error("rs_bank: field widths must be positive");
      end
   endgenerate

   logic [NUM_ENT-1:0] ent_busy, ent_ready, free_oh, alloc, grant;
   logic [IDX_W-1:0]   free_idx, grant_idx;
   logic               any_free, any_ready;

   logic [OP_W-1:0]  ent_op  [NUM_ENT];
   logic [VAL_W-1:0] ent_v1  [NUM_ENT];
   logic [VAL_W-1:0] ent_v2  [NUM_ENT];
   logic [IMM_W-1:0] ent_imm [NUM_ENT];

   rs_free_pick #(.N(NUM_ENT)) u_free (
      .busy     (ent_busy),
      .any_free (any_free),
      .free_oh  (free_oh),
      .free_idx (free_idx)
   );

   // R2: nothing is written when no entry is free
   assign alloc = free_oh & {NUM_ENT{iss_valid & any_free}};

   generate
      for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
         rs_entry #(
            .TAG_W   (TAG_W),
            .VAL_W   (VAL_W),
            .OP_W    (OP_W),
            .IMM_W   (IMM_W),
            .ENT_TAG (TAG_BASE + g)
         ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc[g]),
            .in_op    (iss_op),
            .in_t1    (iss_src1_tag),
            .in_v1    (iss_src1_val),
            .in_t2    (iss_src2_tag),
            .in_v2    (iss_src2_val),
            .in_imm   (iss_imm),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_val   (bc_val),
            .disp     (grant[g] & fu_ready),
            .busy_o   (ent_busy[g]),
            .ready_o  (ent_ready[g]),
            .op_o     (ent_op[g]),
            .v1_o     (ent_v1[g]),
            .v2_o     (ent_v2[g]),
            .imm_o    (ent_imm[g])
         );
      end
   endgenerate

   rs_age_pick #(.N(NUM_ENT), .POLICY(PICK)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (alloc),
      .ready     (ent_ready),
      .grant     (grant),
      .any_ready (any_ready),
      .grant_idx (grant_idx)
   );

   // R10: one-hot payload mux
   always_comb begin
      fu_op   = '0;
      fu_val1 = '0;
      fu_val2 = '0;
      fu_imm  = '0;
      for (int i = 0; i < NUM_ENT; i++) begin
         fu_op   |= ent_op[i]  & {OP_W{grant[i]}};
         fu_val1 |= ent_v1[i]  & {VAL_W{grant[i]}};
         fu_val2 |= ent_v2[i]  & {VAL_W{grant[i]}};
         fu_imm  |= ent_imm[i] & {IMM_W{grant[i]}};
      end
   end

   assign fu_valid  = any_ready;
   assign fu_tag    = TAG_W'(TAG_BASE) + TAG_W'(grant_idx);
   assign iss_ready = any_free;
   assign iss_tag   = TAG_W'(TAG_BASE) + TAG_W'(free_idx);
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
   parameter int N        = 4,
   parameter int TAG_W    = 3,
   parameter int TAG_BASE = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_ready,
   input logic [TAG_W-1:0] iss_tag,
   input logic             bc_valid,
   input logic [TAG_W-1:0] bc_tag,
   input logic             fu_valid,
   input logic             fu_ready,
   input logic [N-1:0]     busy_vec,
   input logic [N-1:0]     grant_vec
);
   // R2: a full bank refuses issue
   a_r2_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy_vec) |-> !iss_ready);

   // R3: offered tag is never the reserved value and lies in the bank's range
   a_r3_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ready |-> (iss_tag != '0) && (int'(iss_tag) >= TAG_BASE) && (int'(iss_tag) < TAG_BASE + N));

   // R7: an offered operation is not withdrawn before it is taken
   a_r7_offer_persist: assert property (@(posedge clk) disable iff (!rst_n)
      (fu_valid && !fu_ready) |=> fu_valid);

   // R8: at most one entry selected
   a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec));

   // R9: an entry is released only after its own tag was broadcast
   generate
      for (genvar g = 0; g < N; g++) begin : g_rel
         a_r9_release_on_tag: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy_vec[g]) |-> ($past(bc_valid) && ($past(bc_tag) == TAG_W'(TAG_BASE + g))));
      end
   endgenerate
endmodule

bind rs_bank rs_bank_chk #(
   .N        (NUM_ENT),
   .TAG_W    (TAG_W),
   .TAG_BASE (TAG_BASE)
) u_rs_bank_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_ready (iss_ready),
   .iss_tag   (iss_tag),
   .bc_valid  (bc_valid),
   .bc_tag    (bc_tag),
   .fu_valid  (fu_valid),
   .fu_ready  (fu_ready),
   .busy_vec  (ent_busy),
   .grant_vec (grant)
);

// File: tb/rs_bank_bench.sv
module rs_bank_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int TW = 3;
   localparam int VW = 32;
   localparam int OW = 4;
   localparam int IW = 8;

   logic clk = 1'b0, rst_n;
   logic iss_valid, iss_ready;
   logic [TW-1:0] iss_tag, iss_src1_tag, iss_src2_tag;
   logic [OW-1:0] iss_op;
   logic [VW-1:0] iss_src1_val, iss_src2_val;
   logic [IW-1:0] iss_imm;
   logic bc_valid;
   logic [TW-1:0] bc_tag;
   logic [VW-1:0] bc_val;
   logic fu_valid, fu_ready;
   logic [OW-1:0] fu_op;
   logic [VW-1:0] fu_val1, fu_val2;
   logic [IW-1:0] fu_imm;
   logic [TW-1:0] fu_tag;

   rs_bank #(.NUM_ENT(N), .TAG_W(TW), .VAL_W(VW), .OP_W(OW), .IMM_W(IW), .TAG_BASE(1)) u_rs_bank (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
      .iss_op(iss_op), .iss_src1_tag(iss_src1_tag), .iss_src1_val(iss_src1_val),
      .iss_src2_tag(iss_src2_tag), .iss_src2_val(iss_src2_val), .iss_imm(iss_imm),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .fu_valid(fu_valid), .fu_ready(fu_ready), .fu_op(fu_op),
      .fu_val1(fu_val1), .fu_val2(fu_val2), .fu_imm(fu_imm), .fu_tag(fu_tag)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   // reference model of the entries
   bit            m_busy [N];
   bit            m_sent [N];
   logic [TW-1:0] m_t1 [N];
   logic [TW-1:0] m_t2 [N];
   logic [VW-1:0] m_v1 [N];
   logic [VW-1:0] m_v2 [N];
   logic [OW-1:0] m_op [N];
   logic [IW-1:0] m_imm [N];
   int unsigned   m_seq [N];
   int unsigned   seq_ctr = 0;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_free();
      for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
      return -1;
   endfunction

   function automatic int exp_pick();
      int best = -1;
      for (int i = 0; i < N; i++) begin
         if (m_busy[i] && !m_sent[i] && m_t1[i] == 0 && m_t2[i] == 0) begin
            if (best < 0 || m_seq[i] < m_seq[best]) best = i;
         end
      end
      return best;
   endfunction

   task automatic compare_all();
      int fi = exp_free();
      int pi = exp_pick();
      chk("R2", "iss_ready", 64'(iss_ready), 64'(fi >= 0));
      if (fi >= 0) chk("R3", "iss_tag", 64'(iss_tag), 64'(fi + 1));
      chk("R7", "fu_valid", 64'(fu_valid), 64'(pi >= 0));
      if (pi >= 0) begin
         chk("R8", "fu_tag", 64'(fu_tag), 64'(pi + 1));
         chk("R10", "fu_op", 64'(fu_op), 64'(m_op[pi]));
         chk("R10", "fu_imm", 64'(fu_imm), 64'(m_imm[pi]));
         chk("R5", "fu_val1", 64'(fu_val1), 64'(m_v1[pi]));
         chk("R5", "fu_val2", 64'(fu_val2), 64'(m_v2[pi]));
      end
   endtask

   task automatic set_idle();
      iss_valid = 0; iss_op = '0; iss_src1_tag = '0; iss_src1_val = '0;
      iss_src2_tag = '0; iss_src2_val = '0; iss_imm = '0;
      bc_valid = 0; bc_tag = '0; bc_val = '0; fu_ready = 0;
   endtask

   task automatic step(input bit iv, input logic [OW-1:0] op,
                       input logic [TW-1:0] t1, input logic [VW-1:0] v1,
                       input logic [TW-1:0] t2, input logic [VW-1:0] v2,
                       input logic [IW-1:0] imm, input bit bv,
                       input logic [TW-1:0] bt, input logic [VW-1:0] bval, input bit fr);
      int fi, pi;
      @(negedge clk);
      iss_valid = iv; iss_op = op; iss_src1_tag = t1; iss_src1_val = v1;
      iss_src2_tag = t2; iss_src2_val = v2; iss_imm = imm;
      bc_valid = bv; bc_tag = bt; bc_val = bval; fu_ready = fr;
      #1;
      compare_all();
      fi = exp_free();
      pi = exp_pick();
      @(posedge clk);
      for (int i = 0; i < N; i++) begin
         if (m_busy[i]) begin
            if (bv && m_t1[i] != 0 && m_t1[i] == bt) begin m_t1[i] = 0; m_v1[i] = bval; end
            if (bv && m_t2[i] != 0 && m_t2[i] == bt) begin m_t2[i] = 0; m_v2[i] = bval; end
            if (m_sent[i] && bv && bt == TW'(i + 1)) begin m_busy[i] = 0; m_sent[i] = 0; end
         end
      end
      if (pi >= 0 && fr) m_sent[pi] = 1;
      if (iv && fi >= 0) begin
         m_busy[fi] = 1; m_sent[fi] = 0; m_op[fi] = op; m_imm[fi] = imm;
         if (bv && t1 != 0 && t1 == bt) begin m_t1[fi] = 0; m_v1[fi] = bval; end
         else begin m_t1[fi] = t1; m_v1[fi] = v1; end
         if (bv && t2 != 0 && t2 == bt) begin m_t2[fi] = 0; m_v2[fi] = bval; end
         else begin m_t2[fi] = t2; m_v2[fi] = v2; end
         seq_ctr++;
         m_seq[fi] = seq_ctr;
      end
      #1;
      set_idle();
   endtask

   task automatic peek();
      @(negedge clk);
      #1;
   endtask

   function automatic logic [TW-1:0] rand_src();
      int r = $urandom % 5;
      if (r < 2) return '0;
      if (r < 4) begin
         int k = $urandom % N;
         if (m_busy[k]) return TW'(k + 1);
         return '0;
      end
      return TW'(5 + $urandom % 3);
   endfunction

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      for (int i = 0; i < N; i++) begin
         m_busy[i] = 0; m_sent[i] = 0; m_t1[i] = 0; m_t2[i] = 0;
         m_v1[i] = 0; m_v2[i] = 0; m_op[i] = 0; m_imm[i] = 0; m_seq[i] = 0;
      end
      set_idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      peek();
      // R1: reset state
      chk("R1", "iss_ready", 64'(iss_ready), 64'd1);
      chk("R1", "fu_valid", 64'(fu_valid), 64'd0);
      chk("R1", "iss_tag", 64'(iss_tag), 64'd1);

      // R4: ready values go straight to dispatch
      step(1, 4'h3, 0, 32'hAAAA_0001, 0, 32'hBBBB_0002, 8'h05, 0, 0, 0, 0);
      peek();
      chk("R4", "fu_valid", 64'(fu_valid), 64'd1);
      chk("R4", "fu_val1", 64'(fu_val1), 64'hAAAA_0001);
      chk("R4", "fu_val2", 64'(fu_val2), 64'hBBBB_0002);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      chk("R9", "iss_tag while entry 1 held", 64'(iss_tag), 64'd2);
      step(0, 0, 0, 0, 0, 0, 0, 1, 3'd1, 32'h55, 0);
      peek();
      chk("R9", "iss_tag after release", 64'(iss_tag), 64'd1);
      chk("R9", "fu_valid after release", 64'(fu_valid), 64'd0);

      // R8: older entry at higher index wins
      step(1, 4'h1, 0, 32'h11, 0, 32'h12, 8'h01, 0, 0, 0, 0);
      step(1, 4'h2, 3'd7, 0, 0, 32'h22, 8'h02, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 0, 0, 1, 3'd1, 32'h99, 0);
      step(1, 4'h3, 3'd6, 0, 0, 32'h33, 8'h03, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 1, 3'd7, 32'h77, 0);
      step(0, 0, 0, 0, 0, 0, 0, 1, 3'd6, 32'h66, 0);
      peek();
      chk("R8", "oldest entry offered", 64'(fu_tag), 64'd2);
      chk("R5", "woken operand", 64'(fu_val1), 64'h77);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 0, 0, 1, 3'd2, 32'h1, 1);
      step(0, 0, 0, 0, 0, 0, 0, 1, 3'd1, 32'h2, 0);

      // R6: broadcast in the issue cycle is forwarded
      step(1, 4'h9, 3'd5, 0, 0, 32'h44, 8'h09, 1, 3'd5, 32'h1234_5678, 0);
      peek();
      chk("R6", "fu_valid", 64'(fu_valid), 64'd1);
      chk("R6", "fu_val1", 64'(fu_val1), 64'h1234_5678);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 0, 0, 1, 3'd1, 32'h3, 0);

      // R2: fill the bank, then try one more issue
      for (int k = 0; k < N; k++)
         step(1, 4'(k), 3'd7, 0, 0, 32'(k), 8'(k), 0, 0, 0, 0);
      step(1, 4'hF, 0, 32'hDEAD, 0, 32'hBEEF, 8'hFF, 0, 0, 0, 0);
      peek();
      chk("R2", "iss_ready when full", 64'(iss_ready), 64'd0);
      chk("R7", "nothing eligible", 64'(fu_valid), 64'd0);
      step(0, 0, 0, 0, 0, 0, 0, 1, 3'd7, 32'hC0DE, 0);
      peek();
      chk("R8", "first filled entry offered", 64'(fu_tag), 64'd1);

      // constrained random traffic
      for (int cyc = 0; cyc < 3000; cyc++) begin
         bit bv = 0;
         logic [TW-1:0] bt = '0;
         int r = $urandom % 4;
         if (r < 2) begin
            int st = $urandom % N;
            for (int j = 0; j < N; j++) begin
               int k = (st + j) % N;
               if (!bv && m_busy[k] && m_sent[k]) begin bv = 1; bt = TW'(k + 1); end
            end
         end else if (r == 2) begin
            bv = 1; bt = TW'(5 + $urandom % 3);
         end
         step(($urandom % 3) != 0, OW'($urandom), rand_src(), $urandom,
              rand_src(), $urandom, IW'($urandom), bv, bt, $urandom, ($urandom % 4) != 0);
      end

      summary();
      $finish;
   end
endmodule